// File: doc/BRIEF.md
# Display Clock Domain Power Sequencer

This block brings the display clock domain up and takes it down again, one ordered step at a time. A bring-up request first turns off a reset-handshake enable that no partner device will ever answer. It then looks at whether the display PLL already runs. If the PLL is running, the block finishes at once and leaves the clock alone. If it is not, the block asks an external frequency-change sequencer for the maximum display clock and waits for that sequencer to report completion. Next it raises the data-buffer power request, waits a fixed time and samples the buffer power acknowledge exactly once.

A teardown request runs the reverse order. The block drops the buffer power request, waits the same fixed time and checks that the acknowledge has gone low. It then asks the sequencer for the bypass frequency, which shuts the PLL off. Every operation ends with a one-cycle completion pulse. A one-cycle error pulse accompanies it when a check failed, and a sticky error flag holds until reset. The wait length is set by the number of clock cycles per microsecond times a number of microseconds.

Top module: `dclk_power_ctrl`

## Requirements
- R1: After reset, `partner_hs_en` is 1, and `buf_pwr_req`, `freq_req_valid`, `op_done`, `op_err` and `err_sticky` are all 0. `freq_khz` shows the bypass value `BYPASS_KHZ` (19200 by default).
- R2: An accepted bring-up drives `partner_hs_en` to 0 on the edge that accepts it, before any frequency or buffer request is made. It stays 0 until reset.
- R3: A bring-up that finds `pll_enabled` = 1 one cycle after acceptance ends with `op_done` on the following cycle. It makes no frequency request and leaves `buf_pwr_req` unchanged.
- R4: A bring-up that finds the PLL off holds `freq_req_valid` = 1 with `freq_khz` = `MAX_KHZ` (624000 by default), stable, until a cycle with `freq_done` = 1. `buf_pwr_req` rises on that same edge.
- R5: After `buf_pwr_req` changes, `buf_pwr_state` is sampled once only, on the edge WAIT+1 cycles later, where WAIT = `CYC_PER_US`*`WAIT_US`. Values it takes earlier have no effect. In bring-up, a sampled 0 is an error.
- R6: An accepted teardown drives `buf_pwr_req` to 0 on the accepting edge and waits as in R5. A sampled 1 is an error.
- R7: Once its buffer check is done, a teardown always requests `freq_khz` = `BYPASS_KHZ`, whether the check failed or not, and only while `buf_pwr_req` is 0. `op_done` follows on the cycle after the `freq_done` edge.
- R8: `op_done` is a one-cycle pulse at the end of every operation. `op_err` is high in that same cycle exactly when a check of the operation failed. `err_sticky` goes to 1 on the next cycle and holds until reset.
- R9: Requests are taken only while the block is idle; requests that arrive during an operation are dropped. When both requests arrive together, bring-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bringup_req | input | 1 | Bring-up request pulse |
| teardown_req | input | 1 | Teardown request pulse |
| pll_enabled | input | 1 | Display PLL enable status |
| freq_done | input | 1 | Frequency sequencer completion for the current request |
| buf_pwr_state | input | 1 | Data-buffer power acknowledge |
| partner_hs_en | output | 1 | Reset-handshake enable, cleared by bring-up |
| freq_req_valid | output | 1 | Frequency change request to the sequencer |
| freq_khz | output | FREQ_W | Requested display clock in kHz |
| buf_pwr_req | output | 1 | Data-buffer power request |
| op_done | output | 1 | Operation complete pulse |
| op_err | output | 1 | Operation error pulse, with op_done |
| err_sticky | output | 1 | Error seen since reset |

## Verification
The hardest behaviour to show from the ports is that the buffer acknowledge is sampled once, on one edge, and not polled. The bench drives the acknowledge to the wrong level for the whole wait window and switches it to the right level only in the final cycle before the sampling edge. It also does the opposite, which turns a polled or early-sampled design into a wrong verdict. A second hard case is a teardown whose buffer check fails but which must still request the bypass frequency. The bench holds the acknowledge high across a whole teardown for this. Dropped requests are injected in the middle of a wait, and the bench then watches for side effects on the buffer request and for stray frequency requests.

// File: rtl/dclk_pwr_pkg.sv
package dclk_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLL_CHK,
        ST_FREQ_REQ,
        ST_BUF_WAIT,
        ST_BUF_CHK,
        ST_FINISH
    } seq_state_e;

    typedef enum logic {
        DIR_UP,
        DIR_DOWN
    } seq_dir_e;

    typedef struct packed {
        logic hs_en;
        logic buf_req;
        logic freq_valid;
        logic sel_max;
        logic done;
        logic err;
        logic sticky;
    } seq_out_t;

    function automatic int unsigned wait_cycles(input int unsigned cyc_per_us,
                                                input int unsigned wait_us);
        int unsigned n;
        n = cyc_per_us * wait_us;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/dclk_wait_timer.sv
module dclk_wait_timer #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= CW'(CYCLES - 1);
            active <= 1'b1;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expired = active && (cnt == '0);

endmodule

// File: rtl/dclk_seq_fsm.sv
module dclk_seq_fsm
    import dclk_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     up_req,
    input  logic     down_req,
    input  logic     pll_on,
    input  logic     freq_done,
    input  logic     buf_state,
    input  logic     tmr_expired,
    output logic     tmr_start,
    output seq_out_t ctl
);
    seq_state_e state;
    seq_dir_e   dir;
    logic       hs_en;
    logic       buf_req;
    logic       sel_max;
    logic       err_pend;
    logic       sticky;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dir      <= DIR_UP;
            hs_en    <= 1'b1;
            buf_req  <= 1'b0;
            sel_max  <= 1'b0;
            err_pend <= 1'b0;
            sticky   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (up_req) begin
                        dir      <= DIR_UP;
                        hs_en    <= 1'b0;
                        err_pend <= 1'b0;
                        state    <= ST_PLL_CHK;
                    end else if (down_req) begin
                        dir      <= DIR_DOWN;
                        buf_req  <= 1'b0;
                        err_pend <= 1'b0;
                        state    <= ST_BUF_WAIT;
                    end
                end
                ST_PLL_CHK: begin
                    if (pll_on) begin
                        state <= ST_FINISH;
                    end else begin
                        sel_max <= 1'b1;
                        state   <= ST_FREQ_REQ;
                    end
                end
                ST_FREQ_REQ: begin
                    if (freq_done) begin
                        if (dir == DIR_UP) begin
                            buf_req <= 1'b1;
                            state   <= ST_BUF_WAIT;
                        end else begin
                            state <= ST_FINISH;
                        end
                    end
                end
                ST_BUF_WAIT: begin
                    if (tmr_expired) begin
                        state <= ST_BUF_CHK;
                    end
                end
                ST_BUF_CHK: begin
                    if (dir == DIR_UP) begin
                        if (!buf_state) err_pend <= 1'b1;
                        state <= ST_FINISH;
                    end else begin
                        if (buf_state) err_pend <= 1'b1;
                        sel_max <= 1'b0;
                        state   <= ST_FREQ_REQ;
                    end
                end
                ST_FINISH: begin
                    if (err_pend) sticky <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tmr_start = ((state == ST_IDLE) && !up_req && down_req) ||
                    ((state == ST_FREQ_REQ) && freq_done && (dir == DIR_UP));
    end

    always_comb begin
        ctl.hs_en      = hs_en;
        ctl.buf_req    = buf_req;
        ctl.freq_valid = (state == ST_FREQ_REQ);
        ctl.sel_max    = sel_max;
        ctl.done       = (state == ST_FINISH);
        ctl.err        = (state == ST_FINISH) && err_pend;
        ctl.sticky     = sticky;
    end

endmodule

// File: rtl/dclk_power_ctrl.sv
module dclk_power_ctrl
    import dclk_pwr_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 200,
    parameter int unsigned WAIT_US    = 10,
    parameter int unsigned FREQ_W     = 20,
    parameter int unsigned MAX_KHZ    = 624000,
    parameter int unsigned BYPASS_KHZ = 19200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bringup_req,
    input  logic              teardown_req,
    input  logic              pll_enabled,
    input  logic              freq_done,
    input  logic              buf_pwr_state,
    output logic              partner_hs_en,
    output logic              freq_req_valid,
    output logic [FREQ_W-1:0] freq_khz,
    output logic              buf_pwr_req,
    output logic              op_done,
    output logic              op_err,
    output logic              err_sticky
);
    localparam int unsigned WAIT_CYC = wait_cycles(CYC_PER_US, WAIT_US);

    seq_out_t ctl;
    logic     tmr_start;
    logic     tmr_expired;

    dclk_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    dclk_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .up_req      (bringup_req),
        .down_req    (teardown_req),
        .pll_on      (pll_enabled),
        .freq_done   (freq_done),
        .buf_state   (buf_pwr_state),
        .tmr_expired (tmr_expired),
        .tmr_start   (tmr_start),
        .ctl         (ctl)
    );

    assign partner_hs_en  = ctl.hs_en;
    assign freq_req_valid = ctl.freq_valid;
    assign freq_khz       = ctl.sel_max ? FREQ_W'(MAX_KHZ) : FREQ_W'(BYPASS_KHZ);
    assign buf_pwr_req    = ctl.buf_req;
    assign op_done        = ctl.done;
    assign op_err         = ctl.err;
    assign err_sticky     = ctl.sticky;

endmodule

// File: rtl/dclk_power_ctrl_chk.sv
module dclk_power_ctrl_chk #(
    parameter int unsigned FREQ_W     = 20,
    parameter int unsigned BYPASS_KHZ = 19200
) (
    input logic              clk,
    input logic              rst,
    input logic              freq_done,
    input logic              partner_hs_en,
    input logic              freq_req_valid,
    input logic [FREQ_W-1:0] freq_khz,
    input logic              buf_pwr_req,
    input logic              op_done,
    input logic              op_err,
    input logic              err_sticky
);
    assert_hs_stays_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !partner_hs_en |=> !partner_hs_en);

    assert_buf_after_hs_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_pwr_req) |-> !partner_hs_en);

    assert_freq_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (freq_req_valid && !freq_done) |=> (freq_req_valid && $stable(freq_khz)));

    assert_bypass_after_buf_off_R7: assert property (@(posedge clk) disable iff (rst)
        (freq_req_valid && (freq_khz == FREQ_W'(BYPASS_KHZ))) |-> !buf_pwr_req);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        op_err |-> op_done);

    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
        op_err |=> err_sticky);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

endmodule

bind dclk_power_ctrl dclk_power_ctrl_chk #(
    .FREQ_W     (FREQ_W),
    .BYPASS_KHZ (BYPASS_KHZ)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .freq_done      (freq_done),
    .partner_hs_en  (partner_hs_en),
    .freq_req_valid (freq_req_valid),
    .freq_khz       (freq_khz),
    .buf_pwr_req    (buf_pwr_req),
    .op_done        (op_done),
    .op_err         (op_err),
    .err_sticky     (err_sticky)
);

// File: tb/dclk_power_ctrl_bench.sv
`timescale 1ns/1ps
module dclk_power_ctrl_bench;
    localparam int unsigned CYC_PER_US = 200;
    localparam int unsigned WAIT_US    = 10;
    localparam int unsigned NWAIT      = CYC_PER_US * WAIT_US;
    localparam int unsigned FREQ_W     = 20;
    localparam longint      KHZ_MAX    = 624000;
    localparam longint      KHZ_BYP    = 19200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bringup_req = 1'b0;
    logic teardown_req = 1'b0;
    logic pll_enabled = 1'b0;
    logic freq_done = 1'b0;
    logic buf_pwr_state = 1'b0;
    logic partner_hs_en;
    logic freq_req_valid;
    logic [FREQ_W-1:0] freq_khz;
    logic buf_pwr_req;
    logic op_done;
    logic op_err;
    logic err_sticky;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dclk_power_ctrl #(
        .CYC_PER_US (CYC_PER_US),
        .WAIT_US    (WAIT_US),
        .FREQ_W     (FREQ_W)
    ) u_dclk_power_ctrl (
        .clk            (clk),
        .rst            (rst),
        .bringup_req    (bringup_req),
        .teardown_req   (teardown_req),
        .pll_enabled    (pll_enabled),
        .freq_done      (freq_done),
        .buf_pwr_state  (buf_pwr_state),
        .partner_hs_en  (partner_hs_en),
        .freq_req_valid (freq_req_valid),
        .freq_khz       (freq_khz),
        .buf_pwr_req    (buf_pwr_req),
        .op_done        (op_done),
        .op_err         (op_err),
        .err_sticky     (err_sticky)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic up, input logic down);
        @(negedge clk);
        bringup_req  = up;
        teardown_req = down;
        @(negedge clk);
        bringup_req  = 1'b0;
        teardown_req = 1'b0;
    endtask

    task automatic serve_freq(input longint exp_khz, input int delay, input string req);
        int w = 0;
        while (!freq_req_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(freq_req_valid == 1'b1, req, "freq request seen", freq_req_valid, 1);
        chk(longint'(freq_khz) == exp_khz, req, "requested kHz", freq_khz, exp_khz);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            if (!freq_req_valid || longint'(freq_khz) != exp_khz)
                chk(1'b0, req, "freq request held", freq_khz, exp_khz);
        end
        freq_done = 1'b1;
        @(negedge clk);
        freq_done = 1'b0;
    endtask

    // Entered at the negedge right after buf_pwr_req changed.
    task automatic buf_window(input logic during, input logic at_sample);
        buf_pwr_state = during;
        repeat (NWAIT) @(negedge clk);
        buf_pwr_state = at_sample;
    endtask

    task automatic t_reset_state;
        chk(partner_hs_en == 1'b1, "R1", "hs enable after reset", partner_hs_en, 1);
        chk(buf_pwr_req == 1'b0, "R1", "buf req after reset", buf_pwr_req, 0);
        chk(freq_req_valid == 1'b0, "R1", "freq valid after reset", freq_req_valid, 0);
        chk(op_done == 1'b0 && op_err == 1'b0, "R1", "done/err after reset", {op_done, op_err}, 0);
        chk(err_sticky == 1'b0, "R1", "sticky after reset", err_sticky, 0);
        chk(longint'(freq_khz) == KHZ_BYP, "R1", "kHz after reset", freq_khz, KHZ_BYP);
    endtask

    task automatic t_bringup_pll_running;
        pll_enabled = 1'b1;
        pulse(1'b1, 1'b0);
        chk(partner_hs_en == 1'b0, "R2", "hs cleared on accept", partner_hs_en, 1'b0);
        chk(freq_req_valid == 1'b0, "R3", "no freq request", freq_req_valid, 0);
        @(negedge clk);
        chk(op_done == 1'b1, "R3", "done when PLL running", op_done, 1);
        chk(op_err == 1'b0, "R3", "no error when PLL running", op_err, 0);
        chk(buf_pwr_req == 1'b0, "R3", "buf req untouched", buf_pwr_req, 0);
        @(negedge clk);
        chk(op_done == 1'b0, "R8", "done is one cycle", op_done, 0);
        pll_enabled = 1'b0;
    endtask

    task automatic t_bringup_full_ok;
        pulse(1'b1, 1'b0);
        // stray teardown while busy (R9)
        teardown_req = 1'b1;
        @(negedge clk);
        teardown_req = 1'b0;
        chk(buf_pwr_req == 1'b0, "R4", "buf req low before freq done", buf_pwr_req, 0);
        serve_freq(KHZ_MAX, 3, "R4");
        chk(buf_pwr_req == 1'b1, "R4", "buf req after freq done", buf_pwr_req, 1);
        // ack stays low through window, high only at sampling edge
        buf_pwr_state = 1'b0;
        repeat (NWAIT / 2) @(negedge clk);
        teardown_req = 1'b1;
        @(negedge clk);
        teardown_req = 1'b0;
        repeat (NWAIT - NWAIT / 2 - 1) @(negedge clk);
        buf_pwr_state = 1'b1;
        chk(op_done == 1'b0, "R5", "no early done", op_done, 0);
        @(negedge clk);
        chk(op_done == 1'b1, "R5", "done after single sample", op_done, 1);
        chk(op_err == 1'b0, "R5", "ack high at sample is ok", op_err, 0);
        chk(buf_pwr_req == 1'b1, "R9", "busy teardown dropped", buf_pwr_req, 1);
        @(negedge clk);
        chk(err_sticky == 1'b0, "R8", "sticky stays clear", err_sticky, 0);
    endtask

    task automatic t_simultaneous;
        pll_enabled = 1'b1;
        pulse(1'b1, 1'b1);
        chk(buf_pwr_req == 1'b1, "R9", "bring-up wins tie", buf_pwr_req, 1);
        @(negedge clk);
        chk(op_done == 1'b1, "R9", "tie ends as bring-up", op_done, 1);
        pll_enabled = 1'b0;
    endtask

    task automatic t_teardown_ok;
        pulse(1'b0, 1'b1);
        chk(buf_pwr_req == 1'b0, "R6", "buf req dropped on accept", buf_pwr_req, 0);
        chk(freq_req_valid == 1'b0, "R7", "no freq request before check", freq_req_valid, 0);
        bringup_req = 1'b1;
        @(negedge clk);
        bringup_req = 1'b0;
        repeat (NWAIT - 1) @(negedge clk);
        buf_pwr_state = 1'b0;
        @(negedge clk);
        serve_freq(KHZ_BYP, 2, "R7");
        chk(op_done == 1'b1, "R7", "done after bypass", op_done, 1);
        chk(op_err == 1'b0, "R6", "ack low is ok", op_err, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (freq_req_valid || op_done)
                chk(1'b0, "R9", "busy bring-up dropped", {freq_req_valid, op_done}, 0);
        end
        chk(freq_req_valid == 1'b0, "R9", "quiet after teardown", freq_req_valid, 0);
    endtask

    task automatic t_bringup_ack_fails;
        pulse(1'b1, 1'b0);
        serve_freq(KHZ_MAX, 0, "R4");
        buf_window(1'b1, 1'b0);
        @(negedge clk);
        chk(op_done == 1'b1, "R5", "done on failed ack", op_done, 1);
        chk(op_err == 1'b1, "R5", "ack low at sample is error", op_err, 1);
        @(negedge clk);
        chk(err_sticky == 1'b1, "R8", "sticky set", err_sticky, 1);
        chk(op_err == 1'b0, "R8", "err is one cycle", op_err, 0);
    endtask

    task automatic t_teardown_ack_stuck;
        buf_pwr_state = 1'b1;
        pulse(1'b0, 1'b1);
        repeat (NWAIT + 1) @(negedge clk);
        serve_freq(KHZ_BYP, 1, "R7");
        chk(op_done == 1'b1, "R7", "done after stuck ack", op_done, 1);
        chk(op_err == 1'b1, "R6", "stuck ack is error", op_err, 1);
        @(negedge clk);
        chk(err_sticky == 1'b1, "R8", "sticky held", err_sticky, 1);
        buf_pwr_state = 1'b0;
    endtask

    task automatic t_reset_clears;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(err_sticky == 1'b0, "R8", "sticky cleared by reset", err_sticky, 0);
        chk(partner_hs_en == 1'b1, "R1", "hs enable back after reset", partner_hs_en, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_bringup_pll_running();
        t_bringup_full_ok();
        t_simultaneous();
        t_teardown_ok();
        t_bringup_ack_fails();
        t_teardown_ack_stuck();
        t_reset_clears();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule